// File: doc/BRIEF.md
# Duty-Cycled Protection Switch Modulator

This block drives the enable of a pack protection switch when the protection controller asks for anything other than a plain on or off state. The controller picks one of four modes: held off, held on, mostly-on cycling, or mostly-off cycling. Both cycling modes run a repeating period of eight slots. Each slot lasts one base tick, which comes from an external slow timer. The mostly-on pattern is used while charging cells that are too deep in discharge. The mostly-off pattern is used while the whole pack is below the lockout level, to limit heat in the switch.

Every slot in which the switch is open is also a measurement window. When such a slot ends, and the window has lasted at least one settling clock, the block samples a digital charger-present flag. If no charger is seen, the block raises a one-clock charger-lost pulse. It then keeps the switch open until the controller writes a different mode. The controller uses this pulse to fall back to off or to shutdown.

Top module: `duty_switch_mod`

## Requirements
- R1: During and directly after reset, gate_en_o and chg_lost_o are both low, and the block behaves as if the held-off mode (code 2'b00) had been requested.
- R2: Held-off mode (mode_i = 2'b00) drives gate_en_o low from the first clock edge that samples it, whatever the slot position.
- R3: Held-on mode (mode_i = 2'b01) drives gate_en_o high from the first clock edge that samples it, and keeps it high while the mode is held.
- R4: Mostly-on mode (mode_i = 2'b10) uses a period of 8 slots numbered 0 to 7, each one tick long. gate_en_o is high in slots 0 to 6 and low in slot 7.
- R5: Mostly-off mode (mode_i = 2'b11) uses the same 8-slot period. gate_en_o is high in slot 0 only.
- R6: A change of mode_i puts the slot timing into an alignment wait that starts at the next clock edge. During this wait, both cycling modes keep gate_en_o low and take no charger samples. The next tick ends the wait and starts slot 0.
- R7: In a cycling mode, the clock edge that carries the tick ending an off slot samples chg_present_i, provided the slot has lasted at least one clock before that edge. If the flag is low at that edge, chg_lost_o goes high for exactly one clock after it, and gate_en_o is held low from that edge onward.
- R8: The held-low state after a lost charger ignores chg_present_i and further ticks. Only a new value on mode_i clears it, after which the requested pattern resumes through the alignment wait.
- R9: chg_present_i has no effect while the switch is closed or in the held modes: no chg_lost_o pulse comes from those periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Mode request: 00 held off, 01 held on, 10 mostly-on cycling, 11 mostly-off cycling |
| tick_i | input | 1 | One-clock base tick that ends the current slot |
| chg_present_i | input | 1 | Charger-present flag from the analog front end |
| gate_en_o | output | 1 | Enable for the protection switch gate |
| chg_lost_o | output | 1 | One-clock pulse when a charger sample in an off slot finds no charger |

## Verification
The held modes are driven with a charger flag that toggles freely. This shows that the flag only matters inside open-switch windows. The two cycling modes are run with tick spacings from two to five clocks. The shortest spacing exercises the one-clock settling rule, and the longer ones separate slot position from clock count. A directed run takes the charger away during the mostly-off pattern, then restores it. This tells a latched held-low state apart from one that would recover by itself, until a new mode is written. Random mode changes land at arbitrary points in a period and test that every new pattern starts at slot 0 only after the next tick.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ON   = 2'b01,
    MODE_HIGH = 2'b10,
    MODE_LOW  = 2'b11
  } mode_e;
endpackage

// File: rtl/dsm_slot_timer.sv
module dsm_slot_timer #(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              restart_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              align_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic              align_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      align_q <= 1'b1;
    end else if (restart_i) begin
      align_q <= 1'b1;
    end else if (tick_i) begin
      if (align_q) begin
        slot_q  <= '0;
        align_q <= 1'b0;
      end else begin
        slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      end
    end
  end

  assign slot_o  = slot_q;
  assign align_o = align_q;

  // R4 R5: period wraps through all slots in order
  assert_slot_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !align_q && !restart_i) |=>
      (slot_q == (($past(slot_q) == LAST) ? '0 : $past(slot_q) + 1'b1)));

  // R6: leaving the alignment wait always lands on slot 0
  assert_align_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(align_q) |-> (slot_q == '0));
endmodule

// File: rtl/dsm_pattern_gen.sv
module dsm_pattern_gen
  import dsm_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  mode_e             mode_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              align_i,
  input  logic              lost_i,
  output logic              gate_o,
  output logic              off_slot_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic cycling;
  logic pat_on;

  always_comb begin
    cycling = 1'b0;
    pat_on  = 1'b0;
    unique case (mode_i)
      MODE_OFF:  pat_on = 1'b0;
      MODE_ON:   pat_on = 1'b1;
      MODE_HIGH: begin cycling = 1'b1; pat_on = (slot_i != LAST); end
      MODE_LOW:  begin cycling = 1'b1; pat_on = (slot_i == '0);   end
      default:   pat_on = 1'b0;
    endcase
    if (cycling && align_i) pat_on = 1'b0;
  end

  assign gate_o     = pat_on && !lost_i;
  assign off_slot_o = cycling && !align_i && !pat_on;
endmodule

// File: rtl/dsm_charger_check.sv
module dsm_charger_check (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  input  logic off_slot_i,
  input  logic chg_i,
  output logic lost_o,
  output logic pulse_o
);
  logic settle_q;
  logic lost_q;
  logic pulse_q;
  logic sample;
  logic missing;

  assign sample  = tick_i && off_slot_i && settle_q && !lost_q && !restart_i;
  assign missing = sample && !chg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_q <= 1'b0;
      lost_q   <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      if (tick_i || restart_i) settle_q <= 1'b0;
      else if (off_slot_i)     settle_q <= 1'b1;
      if (restart_i)    lost_q <= 1'b0;
      else if (missing) lost_q <= 1'b1;
      pulse_q <= missing;
    end
  end

  assign lost_o  = lost_q;
  assign pulse_o = pulse_q;

  // R7: a loss report only follows a tick that closed an open-switch slot
  assert_pulse_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> $past(tick_i && off_slot_i));

  // R7: the report is a single clock wide
  assert_pulse_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);

  // R8: latched loss only clears on a mode change
  assert_lost_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_q && !restart_i) |=> lost_q);
endmodule

// File: rtl/duty_switch_mod.sv
module duty_switch_mod
  import dsm_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       tick_i,
  input  logic       chg_present_i,
  output logic       gate_en_o,
  output logic       chg_lost_o
);
  localparam int SLOT_W = $clog2(SLOTS);

  mode_e             mode_req;
  mode_e             mode_q;
  logic              restart;
  logic [SLOT_W-1:0] slot;
  logic              align;
  logic              lost;
  logic              off_slot;

  assign mode_req = mode_e'(mode_i);
  assign restart  = (mode_req != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_OFF;
    else         mode_q <= mode_req;
  end

  dsm_slot_timer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .restart_i(restart),
    .slot_o   (slot),
    .align_o  (align)
  );

  dsm_pattern_gen #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_pattern (
    .mode_i    (mode_q),
    .slot_i    (slot),
    .align_i   (align),
    .lost_i    (lost),
    .gate_o    (gate_en_o),
    .off_slot_o(off_slot)
  );

  dsm_charger_check u_check (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_i    (tick_i),
    .off_slot_i(off_slot),
    .chg_i     (chg_present_i),
    .lost_o    (lost),
    .pulse_o   (chg_lost_o)
  );

  // R2: held-off request opens the switch after one edge
  assert_off_fast_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> !gate_en_o);

  // R3: held-on request closes the switch after one edge
  assert_on_fast_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01) |=> gate_en_o);

  // R7: switch is open whenever a loss is reported
  assert_lost_open_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_lost_o |-> !gate_en_o);

  // R9: no loss report while the previous cycle had the switch closed
  assert_no_closed_sample_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chg_lost_o) |-> !$past(gate_en_o));
endmodule

// File: tb/tb_duty_switch_mod.sv
module tb_duty_switch_mod;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       tick_i = 1'b0;
  logic       chg_i = 1'b1;
  logic       gate_en_o;
  logic       chg_lost_o;

  duty_switch_mod #(.SLOTS(SLOTS)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .tick_i       (tick_i),
    .chg_present_i(chg_i),
    .gate_en_o    (gate_en_o),
    .chg_lost_o   (chg_lost_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int tick_div = 3;
  int tick_cnt = 0;
  bit run_cmp = 1'b0;

  // tick generator, driven away from the active edge
  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin tick_cnt <= 0; tick_i <= 1'b1; end
    else begin tick_cnt <= tick_cnt + 1; tick_i <= 1'b0; end
  end

  // reference model built from the requirements
  logic [1:0] m_mode;
  int         m_slot;
  int         m_age;
  bit         m_align, m_lost, m_pulse;
  bit         m_restart, m_sample;

  function automatic bit cyc(logic [1:0] md);
    return md[1];
  endfunction

  function automatic bit pat(logic [1:0] md, int s);
    if (md == 2'b10) return s != SLOTS - 1;  // R4
    if (md == 2'b11) return s == 0;          // R5
    return md == 2'b01;
  endfunction

  function automatic bit exp_gate();
    if (m_lost) return 1'b0;
    if (cyc(m_mode)) return !m_align && pat(m_mode, m_slot);
    return m_mode == 2'b01;
  endfunction

  function automatic bit exp_open_slot();
    return cyc(m_mode) && !m_align && !pat(m_mode, m_slot);
  endfunction

  function automatic string gate_tag();
    if (m_lost) return "R8";
    if (cyc(m_mode) && m_align) return "R6";
    case (m_mode)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 2'b00; m_slot = 0; m_age = 0;
      m_align = 1'b1; m_lost = 1'b0; m_pulse = 1'b0;
    end else begin
      m_restart = (mode_i != m_mode);
      m_sample  = tick_i && (m_age >= 1) && exp_open_slot() && !m_lost && !m_restart;
      m_pulse   = m_sample && !chg_i;
      if (m_restart)    m_lost = 1'b0;
      else if (m_pulse) m_lost = 1'b1;
      if (m_restart) m_align = 1'b1;
      else if (tick_i) begin
        if (m_align) begin m_align = 1'b0; m_slot = 0; end
        else m_slot = (m_slot + 1) % SLOTS;
      end
      if (m_restart || tick_i) m_age = 0;
      else if (m_age < 2)      m_age = m_age + 1;
      m_mode = mode_i;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp && rst_ni) begin
      chk(gate_tag(), gate_en_o, exp_gate());
      chk("R7", chg_lost_o, m_pulse);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  int pulses, highs;

  initial begin
    void'($urandom(32'd2024));
    cycles(3);
    chk("R1", gate_en_o, 1'b0);
    chk("R1", chg_lost_o, 1'b0);
    rst_ni = 1'b1;
    run_cmp = 1'b1;
    cycles(1);
    chk("R1", gate_en_o, 1'b0);

    // held on with a wandering charger flag: no reports (R9)
    mode_i = 2'b01; pulses = 0;
    for (int i = 0; i < 60; i++) begin
      chg_i = i[2];
      @(negedge clk);
      if (chg_lost_o) pulses++;
    end
    chk("R9", pulses == 0, 1'b1);

    // mostly-on with charger present, then forced off mid-period (R2)
    chg_i = 1'b1; tick_div = 4; mode_i = 2'b10;
    cycles(45);
    mode_i = 2'b00;
    cycles(1);
    chk("R2", gate_en_o, 1'b0);
    cycles(10);

    // mostly-off loses the charger: latched open (R7, R8)
    mode_i = 2'b11; tick_div = 3; chg_i = 1'b0;
    cycles(20);
    chg_i = 1'b1; highs = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (gate_en_o) highs++;
    end
    chk("R8", highs == 0, 1'b1);
    mode_i = 2'b10; highs = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (gate_en_o) highs++;
    end
    chk("R8", highs > 0, 1'b1);

    // shortest tick spacing: settling rule (R7)
    tick_div = 2; mode_i = 2'b11; chg_i = 1'b0;
    cycles(30);

    // random phases
    for (int p = 0; p < 40; p++) begin
      mode_i   = 2'($urandom_range(0, 3));
      tick_div = $urandom_range(2, 5);
      for (int c = 0; c < int'($urandom_range(20, 120)); c++) begin
        chg_i = ($urandom_range(0, 15) != 0);
        @(negedge clk);
      end
    end

    run_cmp = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule